// File: doc/BRIEF.md
# PS/2 Wake-on-Key Sequence Detector

This block listens, without ever driving the bus, to the clock and data pair of a PS/2 keyboard. It waits for one programmed scan-code sequence to arrive. The sequence can be a single byte or several bytes in a fixed order, for example a make code with a prefix byte or a break code. Both lines are brought into the system clock domain through flop synchronisers. Each frame is gathered one bit per falling edge of the keyboard clock. A frame counts as good only if its parity is odd, and the final byte of the sequence must also carry a stop bit of 1.

Four sequence variants are held on static inputs, and a 2-bit select picks the one that is active. When the complete sequence is seen, a sticky wake status bit is set and a power-management request goes out. That status stays set until the clear strobe is pulsed. There is no data stream at either edge of the block, so every pin is a plain control or status level. Neither pin has a handshake, and nothing is ever back-pressured.

Top module: `ps2_wake_detect`

## Requirements
- R1: After reset, `wake_sts_o` and `pme_o` are 0.
- R2: A frame is built from 11 falling edges of `ps2_clk_i`. The first edge carries a start bit of 0, the next eight carry data LSB first, the tenth carries parity and the eleventh carries the stop bit. A received single byte that equals the selected one-byte sequence sets the status, and any other byte (including a bit-reversed one) does not.
- R3: A byte is accepted only when its 8 data bits and its parity bit hold an odd number of ones. A byte that fails this check never matches, and it returns the matcher to the first byte of the sequence.
- R4: The last byte of the sequence sets the status only when its stop bit is 1.
- R5: For sequence variant v, field `len_i[2v+1:2v]` holds the length minus 1. Byte k of variant v sits at `code_i[(4v+k)*8 +: 8]`. The bytes must arrive in order, with k = 0 first.
- R6: A byte that breaks a partial match is checked again against byte 0 of the sequence, so a repeated prefix byte does not lose the match.
- R7: `sel_i` picks which of the four variants is compared. A sequence that belongs to another variant does not set the status.
- R8: `wake_sts_o` stays 1 until `clr_i` is pulsed, and a new match wins over a clear in the same cycle.
- R9: While `en_i` is 0, no match is declared and the status keeps its value.
- R10: If no falling clock edge arrives for `TO_CYC` cycles in the middle of a frame, the frame is dropped. The bit counter and the sequence matcher then both return to their start.
- R11: `wake_sts_o` and `pme_o` go high within 5 system clock cycles after the stop-bit falling edge of the last byte appears on `ps2_clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ps2_clk_i | input | 1 | PS/2 clock line, snooped |
| ps2_dat_i | input | 1 | PS/2 data line, snooped |
| code_i | input | 128 | Sequence bytes, four variants of four bytes |
| len_i | input | 8 | Per-variant sequence length minus 1 |
| sel_i | input | 2 | Active variant select |
| en_i | input | 1 | Detection enable |
| clr_i | input | 1 | Status clear strobe |
| wake_sts_o | output | 1 | Sticky wake status |
| pme_o | output | 1 | Power-management wake request |

## Verification
Several rules are checked on every cycle:
- A match only ever follows an accepted frame that had good parity, a stop bit of 1 and detection enabled.
- Frames are never produced back to back.
- The status sets, holds and clears exactly as its rules state.

Some behaviour can only be shown by the bench scenarios:
- The bit order and the variant decoding.
- The in-order multi-byte matching and the prefix recovery.
- The effect of a parity error in the middle of a sequence.
- The mid-frame timeout.
- The five-cycle latency.

// File: rtl/ps2wk_pkg.sv
package ps2wk_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       par_ok;
    logic       stop_ok;
  } ps2wk_byte_t;
endpackage

// File: rtl/ps2wk_sync.sv
module ps2wk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_clk_i,
  input  logic line_dat_i,
  output logic fall_o,
  output logic dat_o
);
  logic [STAGES-1:0] c_sr, d_sr;
  logic              c_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_sr   <= '1;
      d_sr   <= '1;
      c_prev <= 1'b1;
    end else begin
      c_sr   <= {c_sr[STAGES-2:0], line_clk_i};
      d_sr   <= {d_sr[STAGES-2:0], line_dat_i};
      c_prev <= c_sr[STAGES-1];
    end
  end

  assign fall_o = c_prev & ~c_sr[STAGES-1];
  assign dat_o  = d_sr[STAGES-1];
endmodule

// File: rtl/ps2wk_frame.sv
module ps2wk_frame
  import ps2wk_pkg::*;
#(
  parameter int TO_CYC = 100000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fall_i,
  input  logic        dat_i,
  output logic        byte_vld_o,
  output ps2wk_byte_t byte_o,
  output logic        abort_o
);
  localparam int TOW = $clog2(TO_CYC + 1);

  logic [3:0]     bit_cnt;
  logic [7:0]     shreg;
  logic           par_q;
  logic [TOW-1:0] idle_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      par_q      <= 1'b0;
      idle_cnt   <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      abort_o    <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      abort_o    <= 1'b0;
      if (fall_i) begin
        idle_cnt <= '0;
        if (bit_cnt == 4'd0) begin
          if (!dat_i) bit_cnt <= 4'd1;
        end else if (bit_cnt <= 4'd8) begin
          shreg   <= {dat_i, shreg[7:1]};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (bit_cnt == 4'd9) begin
          par_q   <= dat_i;
          bit_cnt <= 4'd10;
        end else begin
          byte_vld_o     <= 1'b1;
          byte_o.data    <= shreg;
          byte_o.par_ok  <= ^{shreg, par_q};
          byte_o.stop_ok <= dat_i;
          bit_cnt        <= 4'd0;
        end
      end else if (bit_cnt != 4'd0) begin
        if (idle_cnt == TOW'(TO_CYC)) begin
          bit_cnt  <= 4'd0;
          idle_cnt <= '0;
          abort_o  <= 1'b1;
        end else begin
          idle_cnt <= idle_cnt + TOW'(1);
        end
      end else begin
        idle_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/ps2wk_match.sv
module ps2wk_match
  import ps2wk_pkg::*;
#(
  parameter int MAX_LEN = 4,
  parameter int SELW    = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              en_i,
  input  logic [SELW-1:0]                   sel_i,
  input  logic [(1<<SELW)*MAX_LEN*8-1:0]    code_i,
  input  logic [(1<<SELW)*$clog2(MAX_LEN)-1:0] len_i,
  input  logic                              byte_vld_i,
  input  ps2wk_byte_t                       byte_i,
  input  logic                              abort_i,
  output logic                              hit_o
);
  localparam int NVAR = 1 << SELW;
  localparam int LENW = $clog2(MAX_LEN);

  logic [7:0]      tbl  [NVAR][MAX_LEN];
  logic [LENW-1:0] lens [NVAR];
  logic [LENW-1:0] idx;
  logic [7:0]      cur_b, first_b;
  logic            at_last;

  for (genvar v = 0; v < NVAR; v++) begin : g_var
    assign lens[v] = len_i[v*LENW +: LENW];
    for (genvar k = 0; k < MAX_LEN; k++) begin : g_pos
      assign tbl[v][k] = code_i[(v*MAX_LEN + k)*8 +: 8];
    end
  end

  assign cur_b   = tbl[sel_i][idx];
  assign first_b = tbl[sel_i][0];
  assign at_last = (idx >= lens[sel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx   <= '0;
      hit_o <= 1'b0;
    end else begin
      hit_o <= 1'b0;
      if (!en_i || abort_i) begin
        idx <= '0;
      end else if (byte_vld_i) begin
        if (!byte_i.par_ok) begin
          idx <= '0;
        end else if (byte_i.data == cur_b) begin
          if (at_last) begin
            idx   <= '0;
            hit_o <= byte_i.stop_ok;
          end else begin
            idx <= idx + LENW'(1);
          end
        end else begin
          idx <= (byte_i.data == first_b) ? LENW'(1) : '0;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_wake_detect.sv
module ps2_wake_detect
  import ps2wk_pkg::*;
#(
  parameter int MAX_LEN     = 4,
  parameter int SELW        = 2,
  parameter int TO_CYC      = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 ps2_clk_i,
  input  logic                                 ps2_dat_i,
  input  logic [(1<<SELW)*MAX_LEN*8-1:0]       code_i,
  input  logic [(1<<SELW)*$clog2(MAX_LEN)-1:0] len_i,
  input  logic [SELW-1:0]                      sel_i,
  input  logic                                 en_i,
  input  logic                                 clr_i,
  output logic                                 wake_sts_o,
  output logic                                 pme_o
);
  logic        fall_w, dat_w, byte_vld_w, abort_w, hit_w;
  ps2wk_byte_t byte_w;

  ps2wk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .line_clk_i(ps2_clk_i), .line_dat_i(ps2_dat_i),
    .fall_o(fall_w), .dat_o(dat_w)
  );

  ps2wk_frame #(.TO_CYC(TO_CYC)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fall_i(fall_w), .dat_i(dat_w),
    .byte_vld_o(byte_vld_w), .byte_o(byte_w), .abort_o(abort_w)
  );

  ps2wk_match #(.MAX_LEN(MAX_LEN), .SELW(SELW)) u_match (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i(en_i), .sel_i(sel_i), .code_i(code_i), .len_i(len_i),
    .byte_vld_i(byte_vld_w), .byte_i(byte_w), .abort_i(abort_w),
    .hit_o(hit_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wake_sts_o <= 1'b0;
    else if (hit_w)  wake_sts_o <= 1'b1;
    else if (clr_i)  wake_sts_o <= 1'b0;
  end

  assign pme_o = wake_sts_o;
endmodule

// File: rtl/ps2wk_chk.sv
module ps2wk_chk
  import ps2wk_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        clr_i,
  input logic        wake_sts_o,
  input logic        pme_o,
  input logic        fall_w,
  input logic        hit_w,
  input logic        byte_vld_w,
  input ps2wk_byte_t byte_w
);
  AST_HIT_AFTER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w |-> $past(byte_vld_w)); // R2
  AST_FRAME_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_w |-> $past(fall_w)); // R2
  AST_FRAME_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_w |=> !byte_vld_w); // R2
  AST_HIT_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w |-> $past(byte_w.par_ok)); // R3
  AST_HIT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w |-> $past(byte_w.stop_ok)); // R4
  AST_HIT_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w |-> $past(en_i)); // R9
  AST_STS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w |=> wake_sts_o); // R8
  AST_STS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_sts_o && !clr_i) |=> wake_sts_o); // R8
  AST_STS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_w) |=> !wake_sts_o); // R8
  AST_PME_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pme_o) |-> $past(hit_w)); // R11
endmodule

bind ps2_wake_detect ps2wk_chk u_chk (.*);

// File: tb/sim_ps2_wake_detect.sv
module sim_ps2_wake_detect;
  localparam int CLK_PERIOD = 10;
  localparam int HP         = 8;
  localparam int TO         = 200;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ps2_clk = 1'b1, ps2_dat = 1'b1;
  logic [127:0] code;
  logic [7:0]   lens;
  logic [1:0]   sel = 2'd0;
  logic         en = 1'b1, clr = 1'b0;
  logic         wake, pme;
  logic         sts_at5 = 1'b0;
  int           n_chk = 0, n_fail = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_wake_detect #(.TO_CYC(TO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
    .code_i(code), .len_i(lens), .sel_i(sel), .en_i(en), .clr_i(clr),
    .wake_sts_o(wake), .pme_o(pme)
  );

  // fields: sel[34:33] n[32:31] b0 b1 b2 parmask[6:4] stopmask[3:1] exp[0]
  localparam logic [34:0] VEC [11] = '{
    {2'd0, 2'd1, 8'h1C, 8'h00, 8'h00, 3'b000, 3'b000, 1'b1},
    {2'd0, 2'd1, 8'h1D, 8'h00, 8'h00, 3'b000, 3'b000, 1'b0},
    {2'd0, 2'd1, 8'h38, 8'h00, 8'h00, 3'b000, 3'b000, 1'b0},
    {2'd0, 2'd1, 8'h1C, 8'h00, 8'h00, 3'b001, 3'b000, 1'b0},
    {2'd0, 2'd1, 8'h1C, 8'h00, 8'h00, 3'b000, 3'b001, 1'b0},
    {2'd1, 2'd2, 8'hE0, 8'h75, 8'h00, 3'b000, 3'b000, 1'b1},
    {2'd1, 2'd2, 8'h75, 8'hE0, 8'h00, 3'b000, 3'b000, 1'b0},
    {2'd2, 2'd3, 8'hE0, 8'hF0, 8'h75, 3'b000, 3'b000, 1'b1},
    {2'd1, 2'd3, 8'hE0, 8'hE0, 8'h75, 3'b010, 3'b000, 1'b0},
    {2'd3, 2'd3, 8'hAA, 8'hAA, 8'h55, 3'b000, 3'b000, 1'b1},
    {2'd1, 2'd1, 8'h1C, 8'h00, 8'h00, 3'b000, 3'b000, 1'b0}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 2: return "R2";
      3:       return "R3";
      4:       return "R4";
      5, 6, 7: return "R5";
      8:       return "R3";
      9:       return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [10:0] bits, input int nb);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk) ps2_dat = bits[i];
      repeat (HP) @(negedge clk);
      ps2_clk = 1'b0;
      if (i == 10) begin
        repeat (5) @(negedge clk);
        sts_at5 = wake;
        repeat (HP - 5) @(negedge clk);
      end else begin
        repeat (HP) @(negedge clk);
      end
      ps2_clk = 1'b1;
    end
    ps2_dat = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    logic p;
    p = ~^b;
    if (bad_par) p = ~p;
    send_bits({~bad_stop, p, b, 1'b0}, 11);
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    code = '0;
    code[0*32 + 0 +: 8] = 8'h1C;
    code[1*32 + 0 +: 8] = 8'hE0;
    code[1*32 + 8 +: 8] = 8'h75;
    code[2*32 + 0 +: 8] = 8'hE0;
    code[2*32 + 8 +: 8] = 8'hF0;
    code[2*32 + 16 +: 8] = 8'h75;
    code[3*32 + 0 +: 8] = 8'hAA;
    code[3*32 + 8 +: 8] = 8'h55;
    lens = {2'd1, 2'd2, 2'd1, 2'd0};

    repeat (4) @(negedge clk);
    check("R1 wake after reset", wake, 1'b0);
    check("R1 pme after reset", pme, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 wake idle", wake, 1'b0);

    for (int i = 0; i < 11; i++) begin
      logic [7:0] bs [3];
      sel = VEC[i][34:33];
      bs[0] = VEC[i][30:23];
      bs[1] = VEC[i][22:15];
      bs[2] = VEC[i][14:7];
      pulse_clr();
      for (int k = 0; k < 3; k++) begin
        if (k < int'(VEC[i][32:31]))
          send_frame(bs[k], VEC[i][4+k], VEC[i][1+k]);
      end
      repeat (4) @(negedge clk);
      check(vec_tag(i), wake, VEC[i][0]);
    end

    // R11 latency and request pin
    pulse_clr();
    sel = 2'd0;
    send_frame(8'h1C, 1'b0, 1'b0);
    check("R11 status by 5 cycles", sts_at5, 1'b1);
    check("R11 pme follows", pme, 1'b1);

    // R8 sticky then clear
    send_frame(8'h1D, 1'b0, 1'b0);
    check("R8 status held", wake, 1'b1);
    pulse_clr();
    check("R8 status cleared", wake, 1'b0);
    check("R8 pme cleared", pme, 1'b0);

    // R9 disabled
    en = 1'b0;
    send_frame(8'h1C, 1'b0, 1'b0);
    check("R9 no match when disabled", wake, 1'b0);
    en = 1'b1;
    send_frame(8'h1C, 1'b0, 1'b0);
    en = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 status kept when disabled", wake, 1'b1);
    en = 1'b1;
    pulse_clr();

    // R10 timeout realigns frames
    send_bits({1'b1, 1'b0, 8'h1C, 1'b0}, 5);
    repeat (TO + 50) @(negedge clk);
    send_frame(8'h1C, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    check("R10 frame realigned after timeout", wake, 1'b1);
    pulse_clr();

    // R10 timeout resets the matcher
    sel = 2'd1;
    send_frame(8'hE0, 1'b0, 1'b0);
    send_bits({1'b1, 1'b0, 8'h12, 1'b0}, 3);
    repeat (TO + 50) @(negedge clk);
    send_frame(8'h75, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    check("R10 matcher reset by timeout", wake, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule